// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst access. When a burst begins, it captures a full external address. The two lowest bits of that address set the starting offset inside an aligned group of four words. On each later clock edge where the step input is asserted, the block moves to the next beat. After the fourth beat it wraps back to the starting offset. On an edge where the step input is not asserted, the address is held and the cycle acts as a wait state.

Two beat orders are supported. In linear order the offset counts upward modulo four from the start offset. In interleaved order the offset is the start offset XOR the beat number. A mode input selects the order. The block treats that input as static: it is sampled only on the edge that loads a new burst. The upper address bits come straight from the load register, so they never change during a burst. A new load on any edge replaces a burst that is still running.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `beat` is 0, `offset` is 0 and `burst_addr` is all zeros.
- R2: On an edge with `load` high, `burst_addr` takes the value of `addr_in` and `beat` becomes 0. Both are visible after that edge.
- R3: With linear order captured (`mode_ilv` = 0 at load), `offset` equals (start + `beat`) mod 4. For example, start 1 gives the sequence 1,2,3,0.
- R4: With interleaved order captured (`mode_ilv` = 1 at load), `offset` equals start XOR `beat`. For example, start 2 gives 2,3,0,1 and start 3 gives 3,2,1,0.
- R5: On an edge with `load` low and `step_n` low, `beat` increases by one, modulo 4.
- R6: On an edge with `load` low and `step_n` high, `beat`, `offset` and `burst_addr` all stay unchanged.
- R7: A step taken from beat 3 returns `beat` to 0 and `offset` to the start offset.
- R8: On a load edge, `step_n` has no effect: `beat` is 0 after that edge whatever `step_n` is.
- R9: A load that arrives in the middle of a burst abandons it. The new start address is used and the beat count restarts at 0.
- R10: A change on `mode_ilv` while no load occurs does not change the order of the burst in progress.
- R11: `burst_addr[ADDR_W-1:2]` equals the upper bits of the last loaded address and stays constant until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Starts a new burst from `addr_in` |
| step_n | input | 1 | Active-low advance; high holds the current beat |
| mode_ilv | input | 1 | Beat order: 0 linear, 1 interleaved; captured at load |
| addr_in | input | ADDR_W | External start address |
| burst_addr | output | ADDR_W | Loaded upper bits joined with the current offset |
| offset | output | 2 | Current low-order burst offset |
| beat | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
All three outputs come from registers that update on the same edge as the `load` or `step_n` input that changes them. Every result is therefore due exactly one clock edge after the stimulus, with no extra pipeline stage. The bench drives inputs on the falling edge and samples outputs 1 ns after the next rising edge. At that point it has already advanced its own model by one beat, so the expected and observed values refer to the same edge. The bound checker states the same single-edge relation using `|=>` and `$past`.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step_n,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [1:0]        offset,
  output logic [1:0]        beat
);

  localparam int OFS_W = 2;
  localparam int UP_W  = ADDR_W - OFS_W;

  logic [UP_W-1:0]  upper_q;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic             ilv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b0;
    end else if (load) begin
      upper_q <= addr_in[ADDR_W-1:OFS_W];
      start_q <= addr_in[OFS_W-1:0];
      beat_q  <= '0;
      ilv_q   <= mode_ilv;
    end else if (!step_n) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign offset     = ilv_q ? (start_q ^ beat_q) : (start_q + beat_q);
  assign beat       = beat_q;
  assign burst_addr = {upper_q, offset};

endmodule

module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              step_n,
  input logic              mode_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [1:0]        offset,
  input logic [1:0]        beat
);

  logic seen_mode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_mode <= 1'b0;
    else if (load) seen_mode <= mode_ilv;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (burst_addr == $past(addr_in)) && (beat == 2'd0));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n) |=> beat == $past(beat) + 2'd1);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> $stable(beat) && $stable(burst_addr));

  assert_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(burst_addr[ADDR_W-1:2]));

  assert_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !seen_mode) |=> (offset - beat) == ($past(offset) - $past(beat)));

  assert_ilv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && seen_mode) |=> (offset ^ beat) == ($past(offset) ^ $past(beat)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && beat == 2'd3) |=> beat == 2'd0);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          step_n = 1'b1;
  logic          mode_ilv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] burst_addr;
  logic [1:0]    offset;
  logic [1:0]    beat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_ilv = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .step_n(step_n),
    .mode_ilv(mode_ilv), .addr_in(addr_in),
    .burst_addr(burst_addr), .offset(offset), .beat(beat)
  );

  function automatic logic [1:0] exp_ofs(logic [1:0] s, logic [1:0] b, logic ilv);
    return ilv ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic ld, logic sn, logic md, logic [AW-1:0] a, string tag);
    logic [1:0] ofs;
    @(negedge clk);
    load = ld; step_n = sn; mode_ilv = md; addr_in = a;
    @(posedge clk);
    if (ld) begin
      m_base = a; m_beat = 2'd0; m_ilv = md;
    end else if (!sn) begin
      m_beat = m_beat + 2'd1;
    end
    #1;
    ofs = exp_ofs(m_base[1:0], m_beat, m_ilv);
    chk({tag, " beat"}, 32'(beat), 32'(m_beat));
    chk(m_ilv ? "R4 offset" : "R3 offset", 32'(offset), 32'(ofs));
    chk("R11 upper", 32'(burst_addr[AW-1:2]), 32'(m_base[AW-1:2]));
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 beat", 32'(beat), 0);
    chk("R1 offset", 32'(offset), 0);
    chk("R1 addr", 32'(burst_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", 32'(burst_addr), 0);

    // R3 linear sequence from start 1 with wrap (R7)
    cyc(1, 1, 0, 20'hABCD1, "R2");
    chk("R2 addr", 32'(burst_addr), 32'h000ABCD1);
    cyc(0, 0, 0, '0, "R5");
    chk("R3 seq", 32'(offset), 2);
    cyc(0, 0, 0, '0, "R5");
    cyc(0, 0, 0, '0, "R5");
    chk("R3 seq", 32'(offset), 0);
    cyc(0, 0, 0, '0, "R7");
    chk("R7 wrap", 32'(offset), 1);
    // R6 wait state
    cyc(0, 1, 1, '0, "R6");
    chk("R6 hold", 32'(burst_addr), 32'h000ABCD1);

    // R4 interleaved start 2; step_n low on load edge (R8)
    cyc(1, 0, 1, 20'h12342, "R8");
    chk("R8 beat", 32'(beat), 0);
    cyc(0, 0, 1, '0, "R5");
    chk("R4 seq", 32'(offset), 3);
    cyc(0, 0, 0, '0, "R10");
    chk("R10 order kept", 32'(offset), 0);
    cyc(0, 0, 0, '0, "R5");
    chk("R4 seq", 32'(offset), 1);
    cyc(0, 0, 1, '0, "R7");
    chk("R7 wrap", 32'(offset), 2);

    // interleaved start 3, then override mid-burst (R9)
    cyc(1, 1, 1, 20'h00003, "R2");
    cyc(0, 0, 1, '0, "R5");
    chk("R4 seq", 32'(offset), 2);
    cyc(0, 0, 1, '0, "R5");
    chk("R4 seq", 32'(offset), 1);
    cyc(1, 0, 0, 20'hFFFFE, "R9");
    chk("R9 restart", 32'(burst_addr), 32'h000FFFFE);

    for (int i = 0; i < 3000; i++) begin
      logic ld, sn, md;
      ld = ($urandom_range(5) == 0);
      sn = $urandom_range(2) == 0;
      md = (i % 97 < 50) ? ld & $urandom_range(1) : $urandom_range(1);
      cyc(ld, sn, md, AW'($urandom), ld ? "R9" : (sn ? "R6" : "R5"));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule